// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management end of a single PHY port. A station manager sends it clause-22-style serial frames on a management clock and a shared data line. The block decodes each frame, checks the PHY address, and either returns one 16-bit register over the data line or updates a register. The data line is split into an input, an output and an output enable, so a pad or a pull-up bus can be built around it.

The register bank holds a few control bits that drive outputs of the port. It also holds a read-only status word, a set of event flags that stay high until they are read, an interrupt mask, and a configuration word. At reset three control bits take their default value ORed with a strap input, and the straps are not looked at again after that. A collision-test control bit makes the collision output follow the transmit enable. The interrupt output is high while any unmasked event flag is set.

The management clock is oversampled in the system clock domain. Frames may arrive with or without a run of preamble ones.

Top module: `mdio_slave`

## Requirements
- R1: A frame starts with the bits 0 then 1 (start), then two opcode bits (10 = read, 01 = write), five PHY address bits, five register address bits, two turnaround bits and sixteen data bits, each sent MSB first and sampled on the rising MDC edge. A frame is accepted whether or not it is preceded by a preamble of ones.
- R2: A frame whose PHY address differs from `phy_addr` leaves `mdio_oe` low for the whole frame and changes no register.
- R3: On a read, `mdio_oe` stays low during the first turnaround bit, the block drives 0 during the second, then drives the sixteen data bits MSB first, and releases `mdio_oe` after the last data bit.
- R4: On a write, the block only samples the turnaround bits and stores the sixteen data bits, MSB first, once the last data bit has been sampled.
- R5: Register 1 is read-only: bit 6 reads 1 (frames without preamble are accepted), bit 2 shows `link_up`, and all other bits read 0.
- R6: Register 0 holds isolate (bit 10), duplex (bit 8) and collision test (bit 7). Register 19 bit 0 holds serial select. At reset each of these bits is loaded with its default ORed with its strap input. After reset the straps have no effect, and only writes change these bits, which drive `ctl_isolate`, `ctl_duplex` and `ctl_serial`.
- R7: `col_out` equals `tx_en` while the collision test bit is 1, and is 0 otherwise.
- R8: Register 17 bit i latches high when `events[i]` is high and stays high until register 17 is read. The read returns the latched value and clears it. Masking does not stop latching.
- R9: `irq` is high while any register 17 bit is set whose mask bit in register 18 is 0. A mask bit of 1 blocks that source. Register 18 resets to 0.
- R10: Reads of registers other than 0, 1, 17, 18 and 19 return 0, and writes to them are ignored.
- R11: After reset `mdio_oe` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Data driven onto the line during reads |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| phy_addr | input | 5 | Address this slave answers to |
| strap_isolate | input | 1 | Reset strap ORed into the isolate bit |
| strap_duplex | input | 1 | Reset strap ORed into the duplex bit |
| strap_serial | input | 1 | Reset strap ORed into the serial select bit |
| link_up | input | 1 | Live link status shown in register 1 |
| tx_en | input | 1 | Transmit enable used by collision test |
| events | input | 4 | Status change events, one per flag |
| irq | output | 1 | Unmasked event pending |
| ctl_isolate | output | 1 | Isolate control bit |
| ctl_duplex | output | 1 | Duplex control bit |
| ctl_serial | output | 1 | Serial select control bit |
| col_out | output | 1 | Collision output |

## Verification
Every cycle, the assertions check these rules. Event flags never drop except on a read of register 17, and a high event always sets its flag. A fully masked bank never raises `irq`. Control bits hold still without a write to them. `mdio_oe` is only high during a read, and it drops right after the last data bit. Unimplemented addresses read zero, and `col_out` is low while `tx_en` is low. Only the bench's frame scenarios show the full picture. They show bit-exact read data with and without preamble, the undriven first turnaround bit, and that straps are ignored after reset. They also show that frames to a foreign address have no effect, that clear-on-read works over two consecutive reads, and that writes to read-only and unimplemented registers are ignored.

// File: rtl/mdio_slave_pkg.sv
// Package: shared types and register map for the management slave.
// Assumes register addresses are 5 bits and data words 16 bits.
package mdio_slave_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_HDR,
        FR_TURN,
        FR_DATA,
        FR_SKIP
    } fr_state_t;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] RA_CTRL = 5'd0;
    localparam logic [4:0] RA_STAT = 5'd1;
    localparam logic [4:0] RA_EVT  = 5'd17;
    localparam logic [4:0] RA_MASK = 5'd18;
    localparam logic [4:0] RA_CFG  = 5'd19;

    localparam int CTRL_ISO   = 10;
    localparam int CTRL_DUP   = 8;
    localparam int CTRL_COLT  = 7;
    localparam int STAT_NOPRE = 6;
    localparam int STAT_LINK  = 2;
    localparam int CFG_SERIAL = 0;

endpackage

// File: rtl/mdio_pin_sync.sv
// Module: synchronises MDC and MDIO into the system clock and flags MDC
// rising edges. Assumes the MDC half period spans several system clocks.
// The sampled data bit is taken from the same pipeline depth as the edge.
module mdio_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic mdc_rise,
    output logic smp
);
    localparam int PW = SYNC_STAGES + 1;

    logic [PW-1:0] mdc_pipe;
    logic [PW-1:0] dat_pipe;

    // Shift both pins through matching flop chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_pipe <= '0;
            dat_pipe <= '1;
        end else begin
            mdc_pipe <= {mdc_pipe[PW-2:0], mdc};
            dat_pipe <= {dat_pipe[PW-2:0], mdio_in};
        end
    end

    // Rising edge seen at the last synchronised stage.
    always_comb begin
        mdc_rise = mdc_pipe[SYNC_STAGES-1] & ~mdc_pipe[SYNC_STAGES];
        smp      = dat_pipe[SYNC_STAGES-1];
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
// Module: decodes management frames bit by bit on each MDC rising edge,
// requests register reads and writes, and drives the data line on reads.
// Assumes a preamble is optional: idle ones are skipped until a start 0.
module mdio_frame_fsm
    import mdio_slave_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_rise,
    input  logic              smp,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int HDR_LEN  = 2 + PHY_AW + REG_AW;
    localparam int SKIP_LEN = 2 + DATA_W;
    localparam int CW       = $clog2(SKIP_LEN + 1);
    localparam logic [CW-1:0] HDR_LAST  = CW'(HDR_LEN - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
    localparam logic [CW-1:0] SKIP_LAST = CW'(SKIP_LEN - 1);

    fr_state_t           state;
    logic [CW-1:0]       cnt;
    logic [HDR_LEN-1:0]  hdr;
    logic [DATA_W-1:0]   sh;
    logic                is_rd;
    logic [REG_AW-1:0]   addr_q;

    logic [HDR_LEN-1:0]  hdr_nx;
    logic [1:0]          op_nx;
    logic [PHY_AW-1:0]   phy_nx;
    logic                hdr_done;
    logic                hit;
    logic                op_ok;

    // Decode the header as it completes with the current bit.
    always_comb begin
        hdr_nx   = {hdr[HDR_LEN-2:0], smp};
        op_nx    = hdr_nx[HDR_LEN-1 -: 2];
        phy_nx   = hdr_nx[REG_AW +: PHY_AW];
        rd_addr  = hdr_nx[REG_AW-1:0];
        hdr_done = mdc_rise && (state == FR_HDR) && (cnt == HDR_LAST);
        hit      = (phy_nx == phy_addr);
        op_ok    = (op_nx == OP_RD) || (op_nx == OP_WR);
        rd_en    = hdr_done && hit && (op_nx == OP_RD);
        wr_en    = mdc_rise && (state == FR_DATA) && !is_rd && (cnt == DATA_LAST);
        wr_addr  = addr_q;
        wr_data  = {sh[DATA_W-2:0], smp};
    end

    // Frame sequencer, data shifter and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FR_IDLE;
            cnt      <= '0;
            hdr      <= '0;
            sh       <= '0;
            is_rd    <= 1'b0;
            addr_q   <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
        end else if (mdc_rise) begin
            case (state)
                FR_IDLE: begin
                    if (!smp) state <= FR_START;
                end
                FR_START: begin
                    if (smp) begin
                        state <= FR_HDR;
                        cnt   <= '0;
                    end
                end
                FR_HDR: begin
                    hdr <= hdr_nx;
                    if (cnt == HDR_LAST) begin
                        cnt    <= '0;
                        addr_q <= rd_addr;
                        if (hit && op_ok) begin
                            state <= FR_TURN;
                            is_rd <= (op_nx == OP_RD);
                            if (op_nx == OP_RD) sh <= rd_data;
                        end else begin
                            state <= FR_SKIP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_TURN: begin
                    if (is_rd) begin
                        if (cnt == '0) begin
                            mdio_oe  <= 1'b1;
                            mdio_out <= 1'b0;
                        end else begin
                            mdio_out <= sh[DATA_W-1];
                            sh       <= {sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    if (cnt == CW'(1)) begin
                        state <= FR_DATA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_DATA: begin
                    if (is_rd) begin
                        if (cnt == DATA_LAST) begin
                            mdio_oe  <= 1'b0;
                            mdio_out <= 1'b0;
                        end else begin
                            mdio_out <= sh[DATA_W-1];
                            sh       <= {sh[DATA_W-2:0], 1'b0};
                        end
                    end else begin
                        sh <= wr_data;
                    end
                    if (cnt == DATA_LAST) begin
                        state <= FR_IDLE;
                        is_rd <= 1'b0;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_SKIP: begin
                    if (cnt == SKIP_LAST) begin
                        state <= FR_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    // R3: the line is only driven while a read frame is in progress.
    assert_oe_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> is_rd);

    // R3: the line is released right after the last data bit.
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_rise && state == FR_DATA && is_rd && cnt == DATA_LAST) |=> !mdio_oe);

    // R4: a write commit never coincides with driving the line.
    assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !mdio_oe);
endmodule

// File: rtl/mdio_reg_bank.sv
// Module: the management register bank: control, status, event flags,
// interrupt mask and configuration. Assumes one read or write per frame;
// reading the event register clears the flags it returned.
module mdio_reg_bank
    import mdio_slave_pkg::*;
#(
    parameter int              REG_AW       = 5,
    parameter int              DATA_W       = 16,
    parameter int              EV_W         = 4,
    parameter logic [15:0]     CTRL_DEFAULT = 16'h0000,
    parameter logic [15:0]     CFG_DEFAULT  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strap_isolate,
    input  logic              strap_duplex,
    input  logic              strap_serial,
    input  logic              link_up,
    input  logic [EV_W-1:0]   events,
    output logic              irq,
    output logic              ctl_isolate,
    output logic              ctl_duplex,
    output logic              ctl_colt,
    output logic              ctl_serial
);
    localparam logic [DATA_W-1:0] CTRL_WMASK =
        (DATA_W'(1) << CTRL_ISO) | (DATA_W'(1) << CTRL_DUP) | (DATA_W'(1) << CTRL_COLT);
    localparam logic [DATA_W-1:0] CFG_WMASK = DATA_W'(1) << CFG_SERIAL;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cfg_q;
    logic [EV_W-1:0]   mask_q;
    logic [EV_W-1:0]   lat_q;
    logic              evt_clr;
    logic [DATA_W-1:0] strap_ctrl;
    logic [DATA_W-1:0] strap_cfg;
    logic [DATA_W-1:0] stat_word;

    // Strap images placed on their control bit positions.
    always_comb begin
        strap_ctrl = '0;
        strap_ctrl[CTRL_ISO] = strap_isolate;
        strap_ctrl[CTRL_DUP] = strap_duplex;
        strap_cfg  = '0;
        strap_cfg[CFG_SERIAL] = strap_serial;
        stat_word  = '0;
        stat_word[STAT_NOPRE] = 1'b1;
        stat_word[STAT_LINK]  = link_up;
        evt_clr    = rd_en && (rd_addr == RA_EVT);
    end

    // Writable registers; straps are ORed in only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= (DATA_W'(CTRL_DEFAULT) | strap_ctrl) & CTRL_WMASK;
            cfg_q  <= (DATA_W'(CFG_DEFAULT) | strap_cfg) & CFG_WMASK;
            mask_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CTRL: ctrl_q <= wr_data & CTRL_WMASK;
                RA_CFG:  cfg_q  <= wr_data & CFG_WMASK;
                RA_MASK: mask_q <= wr_data[EV_W-1:0];
                default: ;
            endcase
        end
    end

    // One latch-high flag per event source, cleared by a read.
    for (genvar g = 0; g < EV_W; g++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n) lat_q[g] <= 1'b0;
            else        lat_q[g] <= (lat_q[g] & ~evt_clr) | events[g];
        end
    end

    // Read multiplexer; unknown addresses return zero.
    always_comb begin
        case (rd_addr)
            RA_CTRL: rd_data = ctrl_q;
            RA_STAT: rd_data = stat_word;
            RA_EVT:  rd_data = DATA_W'(lat_q);
            RA_MASK: rd_data = DATA_W'(mask_q);
            RA_CFG:  rd_data = cfg_q;
            default: rd_data = '0;
        endcase
    end

    // Control outputs and the interrupt.
    always_comb begin
        ctl_isolate = ctrl_q[CTRL_ISO];
        ctl_duplex  = ctrl_q[CTRL_DUP];
        ctl_colt    = ctrl_q[CTRL_COLT];
        ctl_serial  = cfg_q[CFG_SERIAL];
        irq         = |(lat_q & ~mask_q);
    end

    // R8: flags only drop on a read of the event register.
    assert_evt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_clr |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

    // R8: an active event always leaves its flag set.
    assert_evt_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|events) |=> ((lat_q & $past(events)) == $past(events)));

    // R9: with every source masked the interrupt stays low.
    assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

    // R6: control bits move only on a write to their register.
    assert_ctrl_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == RA_CTRL) |=> $stable(ctrl_q));

    // R10: unimplemented addresses read as zero.
    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != RA_CTRL && rd_addr != RA_STAT && rd_addr != RA_EVT &&
         rd_addr != RA_MASK && rd_addr != RA_CFG) |-> (rd_data == '0));
endmodule

// File: rtl/mdio_slave.sv
// Module: top of the single-port management slave. Joins the pin
// synchroniser, the frame sequencer and the register bank, and forms the
// collision-test output. Assumes MDC is much slower than clk.
module mdio_slave #(
    parameter int          PHY_AW       = 5,
    parameter int          REG_AW       = 5,
    parameter int          DATA_W       = 16,
    parameter int          EV_W         = 4,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [15:0] CTRL_DEFAULT = 16'h0000,
    parameter logic [15:0] CFG_DEFAULT  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic              strap_isolate,
    input  logic              strap_duplex,
    input  logic              strap_serial,
    input  logic              link_up,
    input  logic              tx_en,
    input  logic [EV_W-1:0]   events,
    output logic              irq,
    output logic              ctl_isolate,
    output logic              ctl_duplex,
    output logic              ctl_serial,
    output logic              col_out
);
    logic              mdc_rise;
    logic              smp;
    logic              rd_en;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              ctl_colt;

    mdio_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .mdc_rise(mdc_rise), .smp(smp)
    );

    mdio_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .smp(smp),
        .phy_addr(phy_addr), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mdio_reg_bank #(
        .REG_AW(REG_AW), .DATA_W(DATA_W), .EV_W(EV_W),
        .CTRL_DEFAULT(CTRL_DEFAULT), .CFG_DEFAULT(CFG_DEFAULT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .strap_isolate(strap_isolate), .strap_duplex(strap_duplex),
        .strap_serial(strap_serial), .link_up(link_up), .events(events),
        .irq(irq), .ctl_isolate(ctl_isolate), .ctl_duplex(ctl_duplex),
        .ctl_colt(ctl_colt), .ctl_serial(ctl_serial)
    );

    // Collision test: reflect transmit enable onto the collision output.
    always_comb col_out = ctl_colt & tx_en;

    // R7: no collision indication without transmit enable.
    assert_col_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !col_out);
endmodule

// File: tb/mdio_slave_bench.sv
// Scoreboard bench: the frame driver pushes expected read words into a
// queue, a monitor collects words from the data line and compares them.
module mdio_slave_bench;
    localparam int HALF = 6;
    localparam logic [4:0] MY_PHY = 5'h0B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdc = 1'b0;
    logic       mdio_in = 1'b1;
    logic       mdio_out, mdio_oe;
    logic       strap_isolate = 1'b1, strap_duplex = 1'b0, strap_serial = 1'b1;
    logic       link_up = 1'b1, tx_en = 1'b0;
    logic [3:0] events = '0;
    logic       irq, ctl_isolate, ctl_duplex, ctl_serial, col_out;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    mdio_slave u_mdio_slave (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .phy_addr(MY_PHY),
        .strap_isolate(strap_isolate), .strap_duplex(strap_duplex),
        .strap_serial(strap_serial), .link_up(link_up), .tx_en(tx_en),
        .events(events), .irq(irq), .ctl_isolate(ctl_isolate),
        .ctl_duplex(ctl_duplex), .ctl_serial(ctl_serial), .col_out(col_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        mdio_in = b;
        half();
        mdc = 1'b1;
        half();
        mdc = 1'b0;
    endtask

    // Drive one frame; for reads push the expected word when a reply is due.
    task automatic frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input logic pre,
                         input logic [15:0] exp, input logic resp);
        if (pre) repeat (32) put_bit(1'b1);
        put_bit(1'b0); put_bit(1'b1);
        put_bit(rd);   put_bit(!rd);
        for (int i = 4; i >= 0; i--) put_bit(phy[i]);
        for (int i = 4; i >= 0; i--) put_bit(ra[i]);
        if (rd) begin
            if (resp) exp_q.push_back(exp);
            mdio_in = 1'b1;
            half();
            chk("R3 first turnaround undriven", 16'(mdio_oe), 16'h0);
            mdc = 1'b1; half(); mdc = 1'b0;
            half();
            chk(resp ? "R3 second turnaround driven" : "R2 foreign read undriven",
                16'(mdio_oe), 16'(resp));
            mdc = 1'b1; half(); mdc = 1'b0;
            repeat (16) put_bit(1'b1);
        end else begin
            put_bit(1'b1); put_bit(1'b0);
            for (int i = 15; i >= 0; i--) put_bit(wd[i]);
        end
        mdio_in = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] ra, input logic [15:0] exp, input logic pre);
        frame(1'b1, MY_PHY, ra, 16'h0, pre, exp, 1'b1);
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] wd);
        frame(1'b0, MY_PHY, ra, wd, 1'b0, 16'h0, 1'b0);
    endtask

    task automatic pulse_evt(input int idx);
        @(negedge clk);
        events[idx] = 1'b1;
        @(negedge clk);
        events = '0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: collect turnaround zero plus 16 bits per driven read.
    initial begin
        int n = 0;
        logic [15:0] word = '0;
        forever begin
            @(posedge mdc);
            if (mdio_oe) begin
                if (n == 0) begin
                    chk("R3 turnaround bit value", 16'(mdio_out), 16'h0);
                end else begin
                    word = {word[14:0], mdio_out};
                end
                n++;
                if (n == 17) begin
                    if (exp_q.size() == 0) begin
                        chk("R2 unexpected reply", word, 16'hxxxx);
                    end else begin
                        chk("R1 R3 read data", word, exp_q.pop_front());
                    end
                    n = 0;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 and R6: reset state.
        chk("R11 oe after reset", 16'(mdio_oe), 16'h0);
        chk("R11 irq after reset", 16'(irq), 16'h0);
        chk("R6 isolate strap", 16'(ctl_isolate), 16'h1);
        chk("R6 duplex strap", 16'(ctl_duplex), 16'h0);
        chk("R6 serial strap", 16'(ctl_serial), 16'h1);
        // R6: straps ignored after reset.
        strap_isolate = 1'b0; strap_duplex = 1'b1; strap_serial = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 straps ignored isolate", 16'(ctl_isolate), 16'h1);
        chk("R6 straps ignored duplex", 16'(ctl_duplex), 16'h0);
        // R1 and R5: status with and without preamble.
        rd(5'd1, 16'h0044, 1'b0);
        rd(5'd1, 16'h0044, 1'b1);
        link_up = 1'b0;
        rd(5'd1, 16'h0040, 1'b0);
        wr(5'd1, 16'hFFFF);
        rd(5'd1, 16'h0040, 1'b0);
        // R6 and R4: control read and write.
        rd(5'd0, 16'h0400, 1'b0);
        wr(5'd0, 16'h0180);
        chk("R4 duplex after write", 16'(ctl_duplex), 16'h1);
        chk("R4 isolate after write", 16'(ctl_isolate), 16'h0);
        rd(5'd0, 16'h0180, 1'b1);
        // R7: collision test.
        tx_en = 1'b1;
        @(negedge clk);
        chk("R7 col follows tx_en", 16'(col_out), 16'h1);
        wr(5'd0, 16'h0100);
        chk("R7 col off without test bit", 16'(col_out), 16'h0);
        tx_en = 1'b0;
        // R2: foreign address.
        frame(1'b0, 5'h0C, 5'd0, 16'h0480, 1'b0, 16'h0, 1'b0);
        chk("R2 foreign write ignored", 16'(ctl_isolate), 16'h0);
        rd(5'd0, 16'h0100, 1'b0);
        frame(1'b1, 5'h0A, 5'd0, 16'h0, 1'b0, 16'h0, 1'b0);
        // R10: unimplemented register.
        wr(5'd5, 16'h1234);
        rd(5'd5, 16'h0000, 1'b0);
        // R8 and R9: event flags and interrupt.
        pulse_evt(2);
        chk("R9 irq on event", 16'(irq), 16'h1);
        rd(5'd17, 16'h0004, 1'b0);
        chk("R8 irq cleared by read", 16'(irq), 16'h0);
        rd(5'd17, 16'h0000, 1'b0);
        wr(5'd18, 16'h0001);
        rd(5'd18, 16'h0001, 1'b0);
        pulse_evt(0);
        chk("R9 masked event no irq", 16'(irq), 16'h0);
        pulse_evt(1);
        chk("R9 unmasked event irq", 16'(irq), 16'h1);
        rd(5'd17, 16'h0003, 1'b0);
        chk("R8 flags cleared", 16'(irq), 16'h0);
        // R6: serial select writable.
        wr(5'd19, 16'h0000);
        chk("R6 serial write", 16'(ctl_serial), 16'h0);
        rd(5'd19, 16'h0000, 1'b0);
        repeat (20) @(negedge clk);
        chk("R3 all replies seen", 16'(exp_q.size()), 16'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule